// File: doc/BRIEF.md
# M/N:D Fractional Clock Divider

This block divides a source clock by a fractional ratio. On average its output toggles at the input rate times M / N. The D value sets how many source cycles in each span of N the output stays high. A phase accumulator adds M on every source edge and wraps modulo N, so each wrap starts a new output period. The output is high while the phase lies below D. Over N source cycles the output therefore shows M periods and a total high time of D cycles.

Software loads the three values in an inverted, offset form. The N field holds the bitwise complement of N − M. The D field holds the bitwise complement of 2D. Both are masked to the counter width. A counter mode field selects dual-edge counting. The values on the configuration pins take effect only on a one-cycle commit pulse. That pulse also restarts the phase at zero.

In every case where the counter is not used, the source clock passes straight through with its own 50 % duty cycle. This covers a non-dual-edge mode, M of zero, M not below N, and the all-zero register set present after reset.

The controller is a three-state machine:
- `ST_PASS`: the source clock is forwarded.
- `ST_DECODE`: the phase is cleared while the new values settle.
- `ST_RUN`: the accumulator drives the output.

Transitions:
- A commit in any state goes to `ST_DECODE`.
- From `ST_DECODE`, the machine goes to `ST_RUN` when the decoded set is runnable, and otherwise to `ST_PASS`.
- Reset enters `ST_PASS`.

Top module: `mnd_frac_div`

## Requirements
- R1: After reset the stored values are all zero, and `div_clk` equals `clk_in` in both halves of every cycle (50 % duty). The same holds after an all-zero set is committed.
- R2: Changes on `cfg_m`, `cfg_n_enc`, `cfg_d_enc` and `cfg_mode` without a `commit` pulse leave the output pattern unchanged.
- R3: The divisor is decoded as N = (~cfg_n_enc + M) mod 2^CNT_W, where M = `cfg_m`.
- R4: The high time is decoded as D = floor(((~cfg_d_enc) mod 2^CNT_W) / 2), so an odd stored 2D rounds down.
- R5: D is clamped as follows. A value below M is raised to M. A value above N − M is then lowered to N − M, and this upper bound wins when the two conflict.
- R6: With `cfg_mode` = 2 (dual-edge) and 0 < M < N, the output repeats with a period of N cycles. Each window of N cycles holds exactly as many high cycles as there are phases k·M mod N (k = 0..N−1) below D. It also holds as many rising edges as that cyclic phase sequence has low-to-high crossings. For coprime M, N with M ≤ D ≤ N − M, this means M rising edges and D high cycles.
- R7: When `cfg_mode` ≠ 2, or M = 0, or M ≥ N, the committed set runs in pass-through: `div_clk` equals `clk_in`.
- R8: A commit restarts the phase at zero. Call the clock edge that samples `commit` edge 0. After edge 1, `div_clk` is low. After edge k ≥ 2, it is high exactly when ((k−2)·M mod N) < D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_m | input | CNT_W | Numerator M |
| cfg_n_enc | input | CNT_W | Complement of N − M |
| cfg_d_enc | input | CNT_W | Complement of 2D |
| cfg_mode | input | 2 | Counter mode; 2 selects dual-edge counting |
| commit | input | 1 | One-cycle pulse that loads the pins and restarts the phase |
| div_clk | output | 1 | Divided clock output |

## Verification
A commit is sampled on edge 0. The first clock edge after it, edge 1, clears the phase and forces the output low. The accumulator pattern then appears from edge 2 onward, each sample lagging the phase by two edges.

The monitor starts counting edges on the falling edge after the commit edge. It samples 2 ns after each rising edge and compares the first 2N+1 samples against the phase sequence computed for that exact offset. It takes the N-cycle high and rising-edge counts from the same samples.

Pass-through is checked with a sample 2 ns into each clock half, where the output must follow the source level. An uncommitted change is judged by N-cycle counts alone, because that measure does not depend on the phase.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_DUAL_EDGE = 2'd2;

    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_DECODE = 2'd1,
        ST_RUN    = 2'd2
    } mnd_state_e;

endpackage

// File: rtl/mnd_shadow.sv
module mnd_shadow
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  m_in,
    input  logic [CNT_W-1:0]  n_enc_in,
    input  logic [CNT_W-1:0]  d_enc_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [CNT_W-1:0]  m_q,
    output logic [CNT_W-1:0]  n_enc_q,
    output logic [CNT_W-1:0]  d_enc_q,
    output logic [MODE_W-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q     <= '0;
            n_enc_q <= '0;
            d_enc_q <= '0;
            mode_q  <= '0;
        end else if (load) begin
            m_q     <= m_in;
            n_enc_q <= n_enc_in;
            d_enc_q <= d_enc_in;
            mode_q  <= mode_in;
        end
    end

    // R2: stored values move only on a commit
    p_hold_without_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(m_q) && $stable(n_enc_q) && $stable(d_enc_q) && $stable(mode_q)));

endmodule

// File: rtl/mnd_decode.sv
module mnd_decode
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]  m_q,
    input  logic [CNT_W-1:0]  n_enc_q,
    input  logic [CNT_W-1:0]  d_enc_q,
    input  logic [MODE_W-1:0] mode_q,
    output logic [CNT_W-1:0]  n_dec,
    output logic [CNT_W-1:0]  d_eff,
    output logic              run_ok
);

    logic [CNT_W-1:0] d_raw;
    logic [CNT_W-1:0] n_less_m;
    logic [CNT_W-1:0] d_floor;

    // R3: N recovered from its complemented offset form
    always_comb begin
        n_dec    = CNT_W'(~n_enc_q + m_q);
        n_less_m = CNT_W'(n_dec - m_q);
    end

    // R4: stored 2D complemented, halved with rounding down
    always_comb begin
        d_raw = CNT_W'((~d_enc_q) >> 1);
    end

    // R5: raise to M first, then cap at N - M (the cap wins)
    always_comb begin
        d_floor = (d_raw < m_q) ? m_q : d_raw;
        d_eff   = (d_floor > n_less_m) ? n_less_m : d_floor;
    end

    // R7: the counter runs only for dual-edge mode with 0 < M < N
    always_comb begin
        run_ok = (mode_q == MODE_DUAL_EDGE) && (m_q != '0) && (m_q < n_dec);
    end

    // R5: the effective high time never exceeds N - M when runnable
    always_comb begin
        if (run_ok) begin
            p_cap_r5: assert (d_eff <= n_less_m);
        end
    end

endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] m_val,
    input  logic [CNT_W-1:0] n_val,
    input  logic [CNT_W-1:0] d_val,
    output logic             level_q
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] phase_q;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] phase_nxt;

    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, m_val};
        if (sum >= {1'b0, n_val}) begin
            phase_nxt = CNT_W'(sum - {1'b0, n_val});
        end else begin
            phase_nxt = CNT_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            level_q <= 1'b0;
        end else if (load) begin
            phase_q <= '0;
            level_q <= 1'b0;
        end else if (run) begin
            phase_q <= phase_nxt;
            level_q <= (phase_q < d_val);
        end
    end

    // R6: the phase stays inside the modulus while counting
    p_phase_below_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase_q < n_val));

    // R8: a load restarts the phase at zero with the output low
    p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase_q == '0 && level_q == 1'b0));

endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_m,
    input  logic [CNT_W-1:0]  cfg_n_enc,
    input  logic [CNT_W-1:0]  cfg_d_enc,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              commit,
    output logic              div_clk
);

    mnd_state_e state_q, state_nxt;

    logic [CNT_W-1:0]  m_q, n_enc_q, d_enc_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  n_dec, d_eff;
    logic              run_ok;
    logic              acc_load, acc_run, use_div;
    logic              level_q;

    mnd_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (commit),
        .m_in     (cfg_m),
        .n_enc_in (cfg_n_enc),
        .d_enc_in (cfg_d_enc),
        .mode_in  (cfg_mode),
        .m_q      (m_q),
        .n_enc_q  (n_enc_q),
        .d_enc_q  (d_enc_q),
        .mode_q   (mode_q)
    );

    mnd_decode #(.CNT_W(CNT_W)) u_decode (
        .m_q     (m_q),
        .n_enc_q (n_enc_q),
        .d_enc_q (d_enc_q),
        .mode_q  (mode_q),
        .n_dec   (n_dec),
        .d_eff   (d_eff),
        .run_ok  (run_ok)
    );

    mnd_accum #(.CNT_W(CNT_W)) u_accum (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .load    (acc_load),
        .run     (acc_run),
        .m_val   (m_q),
        .n_val   (n_dec),
        .d_val   (d_eff),
        .level_q (level_q)
    );

    // State register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PASS:   state_nxt = commit ? ST_DECODE : ST_PASS;
            ST_DECODE: begin
                if (commit) begin
                    state_nxt = ST_DECODE;
                end else begin
                    state_nxt = run_ok ? ST_RUN : ST_PASS;
                end
            end
            ST_RUN:    state_nxt = commit ? ST_DECODE : ST_RUN;
            default:   state_nxt = ST_PASS;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        acc_load = 1'b0;
        acc_run  = 1'b0;
        use_div  = 1'b0;
        unique case (state_q)
            ST_PASS:   ;
            ST_DECODE: acc_load = 1'b1;
            ST_RUN: begin
                acc_run = !commit;
                use_div = 1'b1;
            end
            default:   ;
        endcase
    end

    // R1 / R7: source forwarded whenever the counter is idle
    assign div_clk = use_div ? level_q : clk_in;

    // R8: a commit always passes through the decode state
    p_commit_decode_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
        commit |=> (state_q == ST_DECODE));

    // R7: running is only reached from a runnable stored set
    p_run_needs_ok_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == ST_DECODE && !commit) |=> ((state_q == ST_RUN) == $past(run_ok)));

endmodule

// File: tb/sim_mnd_frac_div.sv
module sim_mnd_frac_div;
    import mnd_pkg::*;

    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cfg_m = '0, cfg_n_enc = '0, cfg_d_enc = '0;
    logic [1:0] cfg_mode = '0;
    logic commit = 1'b0;
    logic div_clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit busy = 1'b0;

    typedef struct {
        string tag;
        bit    pass;
        bit    exact;
        int    m;
        int    n;
        int    d;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    mnd_frac_div #(.CNT_W(W)) u0 (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .cfg_m     (cfg_m),
        .cfg_n_enc (cfg_n_enc),
        .cfg_d_enc (cfg_d_enc),
        .cfg_mode  (cfg_mode),
        .commit    (commit),
        .div_clk   (div_clk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R4/R5: effective high time from the stored 2D and the decoded M, N
    function automatic int deff(input int m, input int n, input int two_d);
        int d;
        d = two_d / 2;
        if (d < m) d = m;
        if (d > n - m) d = n - m;
        return d;
    endfunction

    // Drive a configuration; n/two_d are plain values, encoded here (R3, R4)
    task automatic drive(input int m, input int n, input int two_d, input int mode,
                         input bit do_commit, input exp_t it);
        @(negedge clk);
        cfg_m     = W'(m);
        cfg_n_enc = W'(~(n - m) & MASK);
        cfg_d_enc = W'(~two_d & MASK);
        cfg_mode  = 2'(mode);
        commit    = do_commit;
        @(negedge clk);
        commit = 1'b0;
        q.push_back(it);
        wait (q.size() == 0 && !busy);
    endtask

    function automatic exp_t mk(input string tag, input bit pass, input bit exact,
                                input int m, input int n, input int d);
        exp_t e;
        e.tag = tag; e.pass = pass; e.exact = exact; e.m = m; e.n = n; e.d = d;
        return e;
    endfunction

    // Monitor: pops expected items and compares against the output
    initial begin
        logic samp [0:600];
        forever begin
            exp_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            busy = 1'b1;
            if (it.pass) begin
                int mism = 0;
                for (int i = 0; i < 16; i++) begin
                    @(posedge clk); #2;
                    if (div_clk !== 1'b1) mism++;
                    @(negedge clk); #2;
                    if (div_clk !== 1'b0) mism++;
                end
                chk(mism == 0, {it.tag, " pass-through mismatches"}, mism, 0);
            end else begin
                int hi = 0, rise = 0, exp_hi = 0, exp_rise = 0, mism = 0;
                for (int k = 1; k <= 2 * it.n + 1; k++) begin
                    @(posedge clk); #2;
                    samp[k] = div_clk;
                end
                if (it.exact) begin
                    for (int k = 1; k <= 2 * it.n + 1; k++) begin
                        logic e;
                        e = (k == 1) ? 1'b0 : ((((k - 2) * it.m) % it.n) < it.d);
                        if (samp[k] !== e) mism++;
                    end
                    chk(mism == 0, {it.tag, " R8 sequence mismatches"}, mism, 0);
                end
                for (int k = 0; k < it.n; k++) begin
                    bit cur, prv;
                    cur = ((k * it.m) % it.n) < it.d;
                    prv = (((k + it.n - 1) * it.m) % it.n) < it.d;
                    if (cur) exp_hi++;
                    if (cur && !prv) exp_rise++;
                end
                for (int k = 2; k <= it.n + 1; k++) begin
                    if (samp[k] === 1'b1) hi++;
                    if (samp[k] === 1'b0 && samp[k + 1] === 1'b1) rise++;
                end
                chk(hi == exp_hi, {it.tag, " R6 high cycles"}, hi, exp_hi);
                chk(rise == exp_rise, {it.tag, " R6 rising edges"}, rise, exp_rise);
            end
            busy = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state forwards the source clock
        q.push_back(mk("R1 reset", 1'b1, 1'b0, 0, 0, 0));
        wait (q.size() == 0 && !busy);

        // R3/R4/R6/R8: M=3 N=10 D=4
        drive(3, 10, 8, 2, 1'b1, mk("R3/R4 m3n10d4", 1'b0, 1'b1, 3, 10, deff(3, 10, 8)));
        // R6: M=1 N=4 D=2
        drive(1, 4, 4, 2, 1'b1, mk("R6 m1n4d2", 1'b0, 1'b1, 1, 4, deff(1, 4, 4)));
        // R6: M=5 N=12 D=6
        drive(5, 12, 12, 2, 1'b1, mk("R6 m5n12d6", 1'b0, 1'b1, 5, 12, deff(5, 12, 12)));
        // R4: odd stored 2D=9 rounds down to D=4
        drive(3, 10, 9, 2, 1'b1, mk("R4 odd2d", 1'b0, 1'b1, 3, 10, 4));
        // R5: D=1 raised to M=3
        drive(3, 10, 2, 2, 1'b1, mk("R5 low clamp", 1'b0, 1'b1, 3, 10, 3));
        // R5: D=9 lowered to N-M=7
        drive(3, 10, 18, 2, 1'b1, mk("R5 high clamp", 1'b0, 1'b1, 3, 10, 7));
        // R2: new pins without commit keep the previous pattern
        drive(1, 4, 4, 2, 1'b0, mk("R2 no commit", 1'b0, 1'b0, 3, 10, 7));
        // R5: cap wins when M > N-M (M=7 N=10 -> D=3)
        drive(7, 10, 10, 2, 1'b1, mk("R5 cap wins", 1'b0, 1'b1, 7, 10, 3));
        // R6: wide divisor M=7 N=250 D=100
        drive(7, 250, 200, 2, 1'b1, mk("R6 wide", 1'b0, 1'b1, 7, 250, deff(7, 250, 200)));
        // R7: mode other than dual-edge
        drive(3, 10, 8, 1, 1'b1, mk("R7 mode1", 1'b1, 1'b0, 0, 0, 0));
        // R7: M equal to N
        drive(3, 10, 8, 2, 1'b1, mk("R3 back to run", 1'b0, 1'b1, 3, 10, 4));
        drive(5, 5, 4, 2, 1'b1, mk("R7 m_eq_n", 1'b1, 1'b0, 0, 0, 0));
        // R1: all-zero set committed after running
        drive(3, 10, 8, 2, 1'b1, mk("R8 restart", 1'b0, 1'b1, 3, 10, 4));
        @(negedge clk);
        cfg_m = '0; cfg_n_enc = '0; cfg_d_enc = '0; cfg_mode = '0; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        q.push_back(mk("R1 all-zero", 1'b1, 1'b0, 0, 0, 0));
        wait (q.size() == 0 && !busy);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule